// File: doc/BRIEF.md
# Planar Video Memory Write/Read Datapath

This block sits between an 8-bit CPU data bus and four 8-bit video memory planes that share one address. Each byte address holds eight pixels, and pixel `i` takes its 4-bit colour from bit `i` of each of the four planes. The block keeps four hidden latch bytes that every CPU read refreshes. On a CPU write it builds the four plane bytes from some mix of the CPU byte, a fill colour, the latched bytes, a logic operation and a per-bit mask, depending on the write mode.

On a CPU read it returns either the raw byte of one chosen plane or an 8-bit match map. In the match map each bit tells whether the pixel in that bit position equals a reference colour, and planes can be left out of the comparison. The memory arrays and the address decoding are outside the block. The plane read data arrive combinationally for the address the CPU drives. The plane write enables and data leave combinationally and are taken by the memory at the next rising clock edge. Configuration is written through an index port and a data port, one register per clock. Writes to indices 9 to 15 are ignored.

Top module: `planar_datapath`

## Requirements
- R1: In a cycle with `cpu_rd` high, all four plane bytes on `plane_rdata` (plane p in bits `8p+7:8p`) are captured into the latches at the clock edge. The latches keep their value in cycles without `cpu_rd`.
- R2: With read mode 0 (index 5, bit 4 clear), `cpu_rdata` equals the byte of the plane chosen by index 6 bits 1:0.
- R3: With read mode 1 (index 5, bit 4 set), bit i of `cpu_rdata` is 1 exactly when, for every plane p whose care bit (index 3, bit p) is set, bit i of plane p equals bit p of the match colour (index 2). With no care bits set, the result is 0xFF.
- R4: In write mode 0 (index 5 bits 1:0 = 0), the CPU byte is rotated right by the count in index 4 bits 6:4 before it is used.
- R5: In write mode 0, each plane whose fill-enable bit (index 1, bit p) is set uses eight copies of fill bit p (index 0) in place of the rotated CPU byte.
- R6: In write modes 0 and 2, the source byte is combined with that plane's latch according to index 4 bits 1:0: 0 = pass the source, 1 = AND, 2 = OR, 3 = XOR.
- R7: In write mode 2, plane p's source byte is eight copies of CPU data bit p. Rotation and fill do not apply.
- R8: In write mode 1, every plane is written with its latch byte and the CPU data has no effect.
- R9: For each bit position, a set bit in the bit mask (index 7) passes the combined value, and a clear bit writes the latch bit back.
- R10: `plane_we` equals the plane enable mask (index 8 bits 3:0) in a cycle with `cpu_wr` high, and is 0 otherwise.
- R11: After reset, every register is 0 except the bit mask, which is 0xFF. So writes touch no plane until the enable mask is set, and reads return plane 0.
- R12: Write mode value 3 behaves exactly as write mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Register index |
| cfg_wdata | input | 8 | Register write data |
| cpu_rd | input | 1 | CPU read strobe, loads the latches |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| plane_rdata | input | 32 | Four plane bytes at the current address, plane p in bits 8p+7:8p |
| plane_we | output | 4 | Per-plane write enable |
| plane_wdata | output | 32 | Four plane write bytes, same packing as plane_rdata |
| cpu_rdata | output | 8 | CPU read data, either a plane byte or a match map |

## Verification
Rotation is tried with a CPU byte that changes with the count over all eight counts, so that an off-by-one or a rotation in the wrong direction writes a different byte. The four logic operations are each run against latch bytes that differ from the CPU byte, and this separates AND, OR and XOR from a plain pass. The copy mode is driven from a source address into a different target address with unrelated CPU data, which exposes any leak of CPU data and any latch that failed to load. The compare read is tried with no care bits, all care bits and a partial set, and a long mixed run of random register settings, reads and writes is then checked against a behavioural model byte by byte.

// File: rtl/planar_pkg.sv
package planar_pkg;
    localparam int PLANES    = 4;
    localparam int DW        = 8;
    localparam int ROT_W     = $clog2(DW);
    localparam int PSEL_W    = $clog2(PLANES);
    localparam int CFG_IDX_W = 4;

    localparam logic [CFG_IDX_W-1:0] IDX_FILL_VAL = 4'd0;
    localparam logic [CFG_IDX_W-1:0] IDX_FILL_EN  = 4'd1;
    localparam logic [CFG_IDX_W-1:0] IDX_MATCH    = 4'd2;
    localparam logic [CFG_IDX_W-1:0] IDX_CARE     = 4'd3;
    localparam logic [CFG_IDX_W-1:0] IDX_COMBINE  = 4'd4;
    localparam logic [CFG_IDX_W-1:0] IDX_MODE     = 4'd5;
    localparam logic [CFG_IDX_W-1:0] IDX_RSEL     = 4'd6;
    localparam logic [CFG_IDX_W-1:0] IDX_BMASK    = 4'd7;
    localparam logic [CFG_IDX_W-1:0] IDX_PLANE_EN = 4'd8;

    typedef enum logic [1:0] {
        OP_PASS = 2'd0,
        OP_AND  = 2'd1,
        OP_OR   = 2'd2,
        OP_XOR  = 2'd3
    } comb_op_e;

    typedef enum logic [1:0] {
        WM_MERGE = 2'd0,
        WM_COPY  = 2'd1,
        WM_SPLAT = 2'd2,
        WM_ALIAS = 2'd3
    } wr_mode_e;

    typedef struct packed {
        logic [PLANES-1:0] fill_val;
        logic [PLANES-1:0] fill_en;
        logic [PLANES-1:0] match_val;
        logic [PLANES-1:0] care;
        logic [PLANES-1:0] plane_en;
        logic [ROT_W-1:0]  rot;
        comb_op_e          op;
        wr_mode_e          wmode;
        logic              rmode;
        logic [PSEL_W-1:0] rsel;
        logic [DW-1:0]     bmask;
    } cfg_t;
endpackage

// File: rtl/planar_cfg_regs.sv
module planar_cfg_regs
    import planar_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_IDX_W-1:0] cfg_idx,
    input  logic [DW-1:0]        cfg_wdata,
    output cfg_t                 cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            case (cfg_idx)
                IDX_FILL_VAL: cfg_d.fill_val  = cfg_wdata[PLANES-1:0];
                IDX_FILL_EN:  cfg_d.fill_en   = cfg_wdata[PLANES-1:0];
                IDX_MATCH:    cfg_d.match_val = cfg_wdata[PLANES-1:0];
                IDX_CARE:     cfg_d.care      = cfg_wdata[PLANES-1:0];
                IDX_COMBINE: begin
                    cfg_d.op  = comb_op_e'(cfg_wdata[1:0]);
                    cfg_d.rot = cfg_wdata[4 +: ROT_W];
                end
                IDX_MODE: begin
                    cfg_d.wmode = wr_mode_e'(cfg_wdata[1:0]);
                    cfg_d.rmode = cfg_wdata[4];
                end
                IDX_RSEL:     cfg_d.rsel     = cfg_wdata[PSEL_W-1:0];
                IDX_BMASK:    cfg_d.bmask    = cfg_wdata;
                IDX_PLANE_EN: cfg_d.plane_en = cfg_wdata[PLANES-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q       <= '0;
            cfg_q.bmask <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/planar_write_path.sv
module planar_write_path
    import planar_pkg::*;
(
    input  logic                         cpu_wr,
    input  logic [DW-1:0]                cpu_wdata,
    input  logic [PLANES-1:0][DW-1:0]    latch,
    input  logic [PLANES-1:0]            fill_val,
    input  logic [PLANES-1:0]            fill_en,
    input  logic [PLANES-1:0]            plane_en,
    input  logic [ROT_W-1:0]             rot,
    input  comb_op_e                     op,
    input  wr_mode_e                     wmode,
    input  logic [DW-1:0]                bmask,
    output logic [PLANES-1:0]            plane_we,
    output logic [PLANES-1:0][DW-1:0]    plane_wdata
);
    logic [DW-1:0] rotated;

    always_comb begin
        for (int i = 0; i < DW; i++) begin
            rotated[i] = cpu_wdata[ROT_W'(i) + rot];
        end
    end

    assign plane_we = cpu_wr ? plane_en : '0;

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        logic [DW-1:0] src, combined, merged;

        always_comb begin
            if (wmode == WM_SPLAT) begin
                src = {DW{cpu_wdata[p]}};
            end else if (fill_en[p]) begin
                src = {DW{fill_val[p]}};
            end else begin
                src = rotated;
            end

            case (op)
                OP_AND:  combined = src & latch[p];
                OP_OR:   combined = src | latch[p];
                OP_XOR:  combined = src ^ latch[p];
                default: combined = src;
            endcase

            merged = (combined & bmask) | (latch[p] & ~bmask);
            plane_wdata[p] = (wmode == WM_COPY) ? latch[p] : merged;
        end
    end
endmodule

// File: rtl/planar_read_path.sv
module planar_read_path
    import planar_pkg::*;
(
    input  logic [PLANES-1:0][DW-1:0] plane_rdata,
    input  logic                      rmode,
    input  logic [PSEL_W-1:0]         rsel,
    input  logic [PLANES-1:0]         match_val,
    input  logic [PLANES-1:0]         care,
    output logic [DW-1:0]             cpu_rdata
);
    logic [DW-1:0] match_map;

    always_comb begin
        for (int i = 0; i < DW; i++) begin
            match_map[i] = 1'b1;
            for (int p = 0; p < PLANES; p++) begin
                if (care[p] && (plane_rdata[p][i] != match_val[p])) begin
                    match_map[i] = 1'b0;
                end
            end
        end
    end

    assign cpu_rdata = rmode ? match_map : plane_rdata[rsel];
endmodule

// File: rtl/planar_datapath.sv
module planar_datapath
    import planar_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [CFG_IDX_W-1:0]   cfg_idx,
    input  logic [DW-1:0]          cfg_wdata,
    input  logic                   cpu_rd,
    input  logic                   cpu_wr,
    input  logic [DW-1:0]          cpu_wdata,
    input  logic [PLANES*DW-1:0]   plane_rdata,
    output logic [PLANES-1:0]      plane_we,
    output logic [PLANES*DW-1:0]   plane_wdata,
    output logic [DW-1:0]          cpu_rdata
);
    typedef struct packed {
        logic [PLANES-1:0][DW-1:0] latch;
    } dp_state_t;

    cfg_t                      cfg;
    dp_state_t                 state_d, state_q;
    logic [PLANES-1:0][DW-1:0] rd_planes;
    logic [PLANES-1:0][DW-1:0] wr_planes;

    assign rd_planes   = plane_rdata;
    assign plane_wdata = wr_planes;

    planar_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg)
    );

    always_comb begin
        state_d = state_q;
        if (cpu_rd) begin
            state_d.latch = rd_planes;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    planar_write_path u_wr (
        .cpu_wr      (cpu_wr),
        .cpu_wdata   (cpu_wdata),
        .latch       (state_q.latch),
        .fill_val    (cfg.fill_val),
        .fill_en     (cfg.fill_en),
        .plane_en    (cfg.plane_en),
        .rot         (cfg.rot),
        .op          (cfg.op),
        .wmode       (cfg.wmode),
        .bmask       (cfg.bmask),
        .plane_we    (plane_we),
        .plane_wdata (wr_planes)
    );

    planar_read_path u_rd (
        .plane_rdata (rd_planes),
        .rmode       (cfg.rmode),
        .rsel        (cfg.rsel),
        .match_val   (cfg.match_val),
        .care        (cfg.care),
        .cpu_rdata   (cpu_rdata)
    );
endmodule

module planar_datapath_chk
    import planar_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cpu_rd,
    input logic                 cpu_wr,
    input logic [PLANES*DW-1:0] plane_rdata,
    input logic [PLANES-1:0]    plane_we,
    input logic [PLANES*DW-1:0] plane_wdata,
    input logic [DW-1:0]        cpu_rdata,
    input logic [PLANES*DW-1:0] latch,
    input logic [1:0]           wmode,
    input logic                 rmode,
    input logic [PLANES-1:0]    care,
    input logic [DW-1:0]        bmask
);
    a_r1_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd |=> latch == $past(plane_rdata));

    a_r1_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |=> $stable(latch));

    a_r8_copy_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && wmode == 2'd1) |-> plane_wdata == latch);

    a_r9_mask_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |-> ((plane_wdata ^ latch) & ~{PLANES{bmask}}) == '0);

    a_r10_idle_no_we: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |-> plane_we == '0);

    a_r3_no_care_all: assert property (@(posedge clk) disable iff (!rst_n)
        (rmode && care == '0) |-> cpu_rdata == '1);
endmodule

bind planar_datapath planar_datapath_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_rd      (cpu_rd),
    .cpu_wr      (cpu_wr),
    .plane_rdata (plane_rdata),
    .plane_we    (plane_we),
    .plane_wdata (plane_wdata),
    .cpu_rdata   (cpu_rdata),
    .latch       (state_q.latch),
    .wmode       (cfg.wmode),
    .rmode       (cfg.rmode),
    .care        (cfg.care),
    .bmask       (cfg.bmask)
);

// File: tb/test_planar_datapath.sv
`timescale 1ns/1ps
module test_planar_datapath;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [3:0]  addr = '0;
    logic [31:0] plane_rdata;
    logic [3:0]  plane_we;
    logic [31:0] plane_wdata;
    logic [7:0]  cpu_rdata;

    always #2 clk = ~clk;

    planar_datapath i_planar_datapath (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .plane_rdata(plane_rdata), .plane_we(plane_we),
        .plane_wdata(plane_wdata), .cpu_rdata(cpu_rdata)
    );

    function automatic logic [7:0] pat(int p, int a);
        return 8'((a * 29) + (p * 83) + 17);
    endfunction

    logic [7:0] mem [0:3][0:15];
    always_comb begin
        for (int p = 0; p < 4; p++) plane_rdata[p*8 +: 8] = mem[p][addr];
    end
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < 4; p++)
                for (int a = 0; a < 16; a++) mem[p][a] <= pat(p, a);
        end else begin
            for (int p = 0; p < 4; p++)
                if (plane_we[p]) mem[p][addr] <= plane_wdata[p*8 +: 8];
        end
    end

    // behavioural reference model
    logic [7:0] ref_mem [0:3][0:15];
    logic [7:0] ref_lat [0:3];
    logic [3:0] r_fill, r_fen, r_mval, r_care, r_pen;
    int         r_rot, r_op, r_wm, r_rsel;
    logic       r_rm;
    logic [7:0] r_bm;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(int a);
        logic [7:0] r;
        if (!r_rm) return ref_mem[r_rsel][a];
        for (int i = 0; i < 8; i++) begin
            r[i] = 1'b1;
            for (int p = 0; p < 4; p++)
                if (r_care[p] && ref_mem[p][a][i] != r_mval[p]) r[i] = 1'b0;
        end
        return r;
    endfunction

    function automatic logic [7:0] exp_write(int p, logic [7:0] d);
        logic [7:0] r;
        logic s, l, c;
        for (int i = 0; i < 8; i++) begin
            l = ref_lat[p][i];
            if (r_wm == 1) begin
                r[i] = l;
            end else begin
                if (r_wm == 2)      s = d[p];
                else if (r_fen[p])  s = r_fill[p];
                else                s = d[(i + r_rot) % 8];
                case (r_op)
                    1:       c = s & l;
                    2:       c = s | l;
                    3:       c = s ^ l;
                    default: c = s;
                endcase
                r[i] = r_bm[i] ? c : l;
            end
        end
        return r;
    endfunction

    task automatic cfg(input logic [3:0] idx, input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = v;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        case (idx)
            4'd0: r_fill = v[3:0];
            4'd1: r_fen  = v[3:0];
            4'd2: r_mval = v[3:0];
            4'd3: r_care = v[3:0];
            4'd4: begin r_op = int'(v[1:0]); r_rot = int'(v[6:4]); end
            4'd5: begin r_wm = int'(v[1:0]); r_rm = v[4]; end
            4'd6: r_rsel = int'(v[1:0]);
            4'd7: r_bm   = v;
            4'd8: r_pen  = v[3:0];
            default: ;
        endcase
    endtask

    task automatic rd(input int a, input string tag);
        @(negedge clk);
        cpu_rd = 1'b1; addr = 4'(a);
        #1;
        check(tag, {24'd0, cpu_rdata}, {24'd0, exp_read(a)});
        for (int p = 0; p < 4; p++) ref_lat[p] = ref_mem[p][a];
        @(posedge clk); #1;
        cpu_rd = 1'b0;
    endtask

    task automatic wr(input int a, input logic [7:0] d, input string tag);
        @(negedge clk);
        cpu_wr = 1'b1; addr = 4'(a); cpu_wdata = d;
        #1;
        check("R10 plane enables", {28'd0, plane_we}, {28'd0, r_pen});
        for (int p = 0; p < 4; p++)
            if (r_pen[p]) ref_mem[p][a] = exp_write(p, d);
        @(posedge clk); #1;
        cpu_wr = 1'b0;
        for (int p = 0; p < 4; p++)
            check(tag, {24'd0, mem[p][a]}, {24'd0, ref_mem[p][a]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        for (int p = 0; p < 4; p++) begin
            for (int a = 0; a < 16; a++) ref_mem[p][a] = pat(p, a);
            ref_lat[p] = '0;
        end
        r_fill = '0; r_fen = '0; r_mval = '0; r_care = '0; r_pen = '0;
        r_rot = 0; r_op = 0; r_wm = 0; r_rsel = 0; r_rm = 1'b0; r_bm = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11: reset state
        #1 check("R11 reset no write enables", {28'd0, plane_we}, 32'd0);
        rd(3, "R11 reset read plane 0");
        wr(3, 8'hA5, "R11 reset map mask blocks write");
        cfg(4'd8, 8'h0F);
        wr(3, 8'hA5, "R11 reset bit mask all ones");

        // R2: plane select
        for (int s = 0; s < 4; s++) begin
            cfg(4'd6, 8'(s));
            rd(5, "R2 plane select");
        end

        // R1 / R8: copy through latches
        rd(7, "R2 source read");
        cfg(4'd5, 8'h01);
        wr(9, 8'h3C, "R1 R8 latch copy");
        wr(10, 8'hC3, "R8 cpu data ignored");

        // R4: rotation
        cfg(4'd5, 8'h00);
        rd(2, "R2 prefill latch");
        for (int r = 0; r < 8; r++) begin
            cfg(4'd4, 8'(r << 4));
            wr(2, 8'h81 ^ 8'(r * 5), "R4 rotate right");
        end

        // R5: fill substitution
        cfg(4'd4, 8'h30);
        cfg(4'd0, 8'h0A);
        cfg(4'd1, 8'h06);
        wr(4, 8'h0F, "R5 fill substitution");
        cfg(4'd1, 8'h00);

        // R6: logic operations
        for (int o = 0; o < 4; o++) begin
            rd(6, "R2 latch for op");
            cfg(4'd4, 8'(o));
            wr(6, 8'hC3, "R6 combine op");
        end

        // R7: splat mode with and without op
        cfg(4'd5, 8'h02);
        cfg(4'd4, 8'h50);
        wr(11, 8'h05, "R7 splat mode");
        rd(11, "R2 latch for splat");
        cfg(4'd4, 8'h03);
        wr(11, 8'h0E, "R7 R6 splat xor");

        // R9: bit mask
        cfg(4'd7, 8'h3C);
        cfg(4'd4, 8'h00);
        rd(12, "R2 latch for mask");
        wr(12, 8'hFF, "R9 bit mask splat");
        cfg(4'd5, 8'h00);
        wr(12, 8'h00, "R9 bit mask merge");
        cfg(4'd7, 8'hFF);

        // R10: partial plane enable
        cfg(4'd8, 8'h05);
        wr(13, 8'h77, "R10 plane gating");
        cfg(4'd8, 8'h0F);

        // R12: mode 3 aliases mode 0
        cfg(4'd5, 8'h03);
        cfg(4'd4, 8'h21);
        cfg(4'd1, 8'h08);
        cfg(4'd0, 8'h08);
        wr(14, 8'h6B, "R12 mode 3 as mode 0");
        cfg(4'd1, 8'h00);

        // R3: compare read
        cfg(4'd5, 8'h10);
        cfg(4'd3, 8'h00);
        rd(1, "R3 no care bits");
        cfg(4'd3, 8'h0F);
        for (int c = 0; c < 16; c++) begin
            cfg(4'd2, 8'(c));
            rd(c, "R3 full compare");
        end
        cfg(4'd3, 8'h05);
        cfg(4'd2, 8'h04);
        rd(8, "R3 partial care");
        rd(2, "R3 partial care");

        // mixed run
        lf = 32'h1D2C3B4A;
        for (int n = 0; n < 400; n++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            case (lf[1:0])
                2'd0:    cfg(4'(lf[5:2] % 9), lf[15:8]);
                2'd1:    rd(int'(lf[19:16]), "R3 R2 mixed read");
                default: wr(int'(lf[19:16]), lf[27:20], "R6 R9 mixed write");
            endcase
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule